// File: doc/BRIEF.md
# Self-Adapting Tagged Packet Node

This block is one processing node in a ring of identical nodes. Packets arrive as a stream of 16-bit words, one word per valid/ready handshake. Each packet carries an ordered list of pending operation tags. The node keeps a count for every tag value it sees in the leading position of passing packets. It configures itself to the tag with the largest count, and it may later move to another tag when that tag's count grows larger.

A packet whose leading tag equals the node's current function is processed. Its data words go through a four-tap FIR stage whose coefficients are chosen by the tag. The node then emits the packet with that tag removed and the length word reduced by one. Every other packet leaves the node word for word as it arrived, so it can travel on around the ring. Reconfiguration is modelled as a switch of coefficient set.

Each incoming packet is stored whole in an on-chip buffer before it is sent on. While one packet waits at the output, the headers of later packets are still taken in and counted.

Top module: `adaptive_tag_node`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the node has no configured function.
- R2: While no function is configured, and whenever the leading tag differs from the configured function, a packet leaves the node word-for-word unchanged.
- R3: Packet layout, in word order: word 0 is the total word count of the packet including itself; then zero or more tag words with values 0 to 7; then the delimiter word 16'hFFFF; then the data word count D; then D data words. A packet with no tag words is never processed.
- R4: A processed packet leaves with word 0 reduced by one, its first tag word removed, and its remaining tags, delimiter and data count unchanged.
- R5: In a processed packet, data output n equals the low 16 bits of the sum over k = 0..3 of c_k * x[n-k], where x are the signed input data of the same packet, samples before the first one count as 0, and c_k = (t+1)*(k+1), negated for odd k, with t the tag that was consumed.
- R6: On arrival of every packet with at least one tag, the count of its leading tag rises by one, whether or not the packet is processed. Tag words after the first are not counted.
- R7: The first packet that carries a tag configures the node to that tag, and that packet is processed. Once configured, the node never returns to the unconfigured state.
- R8: The function is re-evaluated only when a packet starts to leave the node. It moves to the tag with the highest count (the lowest tag value wins among equal counts) only if that count is strictly greater than the count of the current function. A tie keeps the current function.
- R9: Counts are 8 bits wide. When an increment would bring a count to 255, every count is halved instead (the incremented one becomes 127), so older traffic weighs less.
- R10: Only the leading tag is compared with the function. A packet whose second tag matches while its first does not is passed unchanged.
- R11: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R12: While an output word is stalled, the node still accepts a following packet as long as buffer space remains, and it emits both packets in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Node can take an input word |
| in_data | input | 16 | Input packet word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 16 | Output packet word |

## Verification
The filter is driven with a unit impulse, which exposes each coefficient of a set on its own, and with a mix of negative and near-full-scale samples, which exposes the sign handling and the truncation to 16 bits. Tagless packets, packets whose second tag matches and packets that tie with the current function all have to come out unchanged, which separates a node that never acts from one that acts too early. A long run of traffic from two competing tags puts the counter halving at a known packet, so that exactly one packet's fate reveals whether halving took place. A stalled output with a second packet sent behind it shows that the output word holds and that the buffer keeps accepting input.

// File: rtl/adnode_pkg.sv
package adnode_pkg;

  typedef enum logic [1:0] {EG_IDLE, EG_FETCH, EG_SHAPE, EG_HOLD} eg_state_t;
  typedef enum logic [1:0] {SEG_LEN, SEG_TAG, SEG_DLEN, SEG_DATA} seg_t;

  // Coefficient k of the set selected by tag value t: (t+1)(k+1), negated on odd k
  function automatic int coef_of(input int t, input int k);
    int mag;
    mag = (t + 1) * (k + 1);
    return (k % 2 == 1) ? -mag : mag;
  endfunction

endpackage

// File: rtl/adnode_pktbuf.sv
module adnode_pktbuf #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/adnode_tally.sv
module adnode_tally #(
  parameter int NTAG  = 8,
  parameter int CNT_W = 8,
  localparam int TAG_W = $clog2(NTAG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [TAG_W-1:0] hit_tag,
  input  logic [TAG_W-1:0] qry_tag,
  output logic [TAG_W-1:0] best_tag,
  output logic [CNT_W-1:0] best_cnt,
  output logic [CNT_W-1:0] qry_cnt
);

  localparam logic [CNT_W-1:0] CSAT = '1;

  logic [CNT_W-1:0] cnt [NTAG];
  logic [CNT_W-1:0] bumped;
  logic             halve;

  assign bumped = cnt[hit_tag] + CNT_W'(1);
  assign halve  = (bumped == CSAT);

  generate
    for (genvar i = 0; i < NTAG; i++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt[i] <= '0;
        end else if (hit) begin
          if (hit_tag == TAG_W'(i)) cnt[i] <= halve ? (bumped >> 1) : bumped;
          else if (halve)           cnt[i] <= cnt[i] >> 1;
        end
      end
    end
  endgenerate

  always_comb begin
    best_tag = '0;
    for (int i = 1; i < NTAG; i++) begin
      if (cnt[i] > cnt[best_tag]) best_tag = TAG_W'(i);
    end
  end

  assign best_cnt = cnt[best_tag];
  assign qry_cnt  = cnt[qry_tag];

endmodule

// File: rtl/adnode_fir.sv
module adnode_fir
  import adnode_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int TAPS   = 4,
  parameter int NTAG   = 8,
  localparam int TAG_W = $clog2(NTAG),
  localparam int ACC_W = 2 * WORD_W + $clog2(TAPS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [WORD_W-1:0] sample,
  input  logic [TAG_W-1:0]  tag,
  output logic [WORD_W-1:0] y
);

  logic [WORD_W-1:0] hist [TAPS-1];
  logic [WORD_W-1:0] xv   [TAPS];

  assign xv[0] = sample;
  generate
    for (genvar k = 1; k < TAPS; k++) begin : g_tap
      assign xv[k] = hist[k-1];
    end
    for (genvar k = 0; k < TAPS - 1; k++) begin : g_hist
      always_ff @(posedge clk) begin
        if (rst || clr)  hist[k] <= '0;
        else if (step)   hist[k] <= xv[k];
      end
    end
  endgenerate

  logic signed [ACC_W-1:0] acc;
  always_comb begin
    logic signed [WORD_W-1:0] xs;
    logic signed [WORD_W-1:0] cs;
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      xs  = $signed(xv[k]);
      cs  = WORD_W'(coef_of(int'(tag), k));
      acc = acc + (ACC_W'(xs) * ACC_W'(cs));
    end
  end

  assign y = acc[WORD_W-1:0];

endmodule

// File: rtl/adaptive_tag_node.sv
module adaptive_tag_node
  import adnode_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NTAG      = 8,
  parameter int CNT_W     = 8,
  parameter int BUF_DEPTH = 64,
  parameter int DQ_DEPTH  = 4,
  parameter int TAPS      = 4,
  parameter logic [WORD_W-1:0] DELIM = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);

  localparam int TAG_W = $clog2(NTAG);
  localparam int AW    = $clog2(BUF_DEPTH);
  localparam int UW    = AW + 1;
  localparam int QAW   = $clog2(DQ_DEPTH);
  localparam int QW    = QAW + 1;
  localparam logic [UW-1:0] DEPTH_U = UW'(BUF_DEPTH);
  localparam logic [QW-1:0] DQ_U    = QW'(DQ_DEPTH);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  // ---------------- ingress ----------------
  logic [1:0]        in_pos;
  logic [WORD_W-1:0] in_rem;
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     in_start;
  logic              in_has;
  logic [TAG_W-1:0]  in_tag;
  logic              in_fire;
  logic              in_last;
  logic              hit;

  logic [UW-1:0]     used;
  logic [QW-1:0]     dq_cnt;
  logic [QAW-1:0]    dq_wp, dq_rp;
  logic [AW-1:0]     dq_start [DQ_DEPTH];
  logic              dq_has   [DQ_DEPTH];
  logic [TAG_W-1:0]  dq_tag   [DQ_DEPTH];

  assign in_ready = (used < DEPTH_U) && (dq_cnt < DQ_U);
  assign in_fire  = in_valid && in_ready;
  assign in_last  = in_fire && (in_pos == 2'd2) && (in_rem == ONE);
  assign hit      = in_fire && (in_pos == 2'd1) && (in_data != DELIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pos   <= 2'd0;
      in_rem   <= '0;
      wr_ptr   <= '0;
      in_start <= '0;
      in_has   <= 1'b0;
      in_tag   <= '0;
    end else if (in_fire) begin
      wr_ptr <= wr_ptr + AW'(1);
      case (in_pos)
        2'd0: begin
          in_start <= wr_ptr;
          in_rem   <= in_data - ONE;
          in_pos   <= 2'd1;
        end
        2'd1: begin
          in_has <= (in_data != DELIM);
          in_tag <= in_data[TAG_W-1:0];
          in_rem <= in_rem - ONE;
          in_pos <= 2'd2;
        end
        default: begin
          in_rem <= in_rem - ONE;
          if (in_rem == ONE) in_pos <= 2'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (in_last) begin
      dq_start[dq_wp] <= in_start;
      dq_has[dq_wp]   <= in_has;
      dq_tag[dq_wp]   <= in_tag;
    end
  end

  // ---------------- statistics ----------------
  logic [TAG_W-1:0] func;
  logic             cfg_valid;
  logic [TAG_W-1:0] best_tag;
  logic [CNT_W-1:0] best_cnt, cur_cnt;

  adnode_tally #(.NTAG(NTAG), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .hit(hit), .hit_tag(in_data[TAG_W-1:0]),
    .qry_tag(func), .best_tag(best_tag), .best_cnt(best_cnt), .qry_cnt(cur_cnt)
  );

  // ---------------- packet buffer ----------------
  logic [AW-1:0]     rd_ptr;
  logic [WORD_W-1:0] rdata;

  adnode_pktbuf #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .we(in_fire), .waddr(wr_ptr), .wdata(in_data),
    .raddr(rd_ptr), .rdata(rdata)
  );

  // ---------------- egress ----------------
  eg_state_t         eg_st;
  seg_t              seg, seg_nx;
  logic              proc;
  logic              tag_first, first_nx;
  logic [WORD_W-1:0] eg_rem;
  logic              sh_emit, sh_skip, fir_step;
  logic [WORD_W-1:0] sh_word, fir_y;
  logic              eg_start, eg_take, eg_pop, eg_idle;
  logic [TAG_W-1:0]  nf;
  logic              nv;

  assign eg_idle  = (eg_st == EG_IDLE);
  assign eg_start = eg_idle && (dq_cnt != '0);
  assign eg_take  = ((eg_st == EG_HOLD) && out_ready) || ((eg_st == EG_SHAPE) && sh_skip);
  assign eg_pop   = (eg_st == EG_HOLD) && out_ready && (eg_rem == ONE);

  // function choice made only at a packet boundary
  always_comb begin
    nf = func;
    nv = cfg_valid;
    if (!cfg_valid) begin
      if (best_cnt != '0) begin
        nf = best_tag;
        nv = 1'b1;
      end
    end else if (best_cnt > cur_cnt) begin
      nf = best_tag;
    end
  end

  adnode_fir #(.WORD_W(WORD_W), .TAPS(TAPS), .NTAG(NTAG)) u_fir (
    .clk(clk), .rst(rst), .clr(eg_start),
    .step(fir_step && (eg_st == EG_SHAPE)),
    .sample(rdata), .tag(func), .y(fir_y)
  );

  always_comb begin
    sh_emit  = 1'b0;
    sh_skip  = 1'b0;
    sh_word  = rdata;
    seg_nx   = seg;
    first_nx = tag_first;
    fir_step = 1'b0;
    case (seg)
      SEG_LEN: begin
        sh_emit  = 1'b1;
        sh_word  = proc ? (rdata - ONE) : rdata;
        seg_nx   = SEG_TAG;
        first_nx = 1'b1;
      end
      SEG_TAG: begin
        if (rdata == DELIM) begin
          sh_emit = 1'b1;
          seg_nx  = SEG_DLEN;
        end else if (proc && tag_first) begin
          sh_skip  = 1'b1;
          first_nx = 1'b0;
        end else begin
          sh_emit  = 1'b1;
          first_nx = 1'b0;
        end
      end
      SEG_DLEN: begin
        sh_emit = 1'b1;
        seg_nx  = SEG_DATA;
      end
      default: begin
        sh_emit = 1'b1;
        if (proc) begin
          sh_word  = fir_y;
          fir_step = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eg_st     <= EG_IDLE;
      seg       <= SEG_LEN;
      proc      <= 1'b0;
      tag_first <= 1'b0;
      eg_rem    <= '0;
      rd_ptr    <= '0;
      func      <= '0;
      cfg_valid <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      case (eg_st)
        EG_IDLE: if (eg_start) begin
          func      <= nf;
          cfg_valid <= nv;
          proc      <= nv && dq_has[dq_rp] && (dq_tag[dq_rp] == nf);
          rd_ptr    <= dq_start[dq_rp];
          seg       <= SEG_LEN;
          eg_st     <= EG_FETCH;
        end
        EG_FETCH: eg_st <= EG_SHAPE;
        EG_SHAPE: begin
          seg       <= seg_nx;
          tag_first <= first_nx;
          if (seg == SEG_LEN) eg_rem <= rdata;
          if (sh_emit) begin
            out_data  <= sh_word;
            out_valid <= 1'b1;
            eg_st     <= EG_HOLD;
          end else begin
            rd_ptr <= rd_ptr + AW'(1);
            eg_rem <= eg_rem - ONE;
            eg_st  <= EG_FETCH;
          end
        end
        default: if (out_ready) begin
          out_valid <= 1'b0;
          rd_ptr    <= rd_ptr + AW'(1);
          eg_rem    <= eg_rem - ONE;
          eg_st     <= (eg_rem == ONE) ? EG_IDLE : EG_FETCH;
        end
      endcase
    end
  end

  // ---------------- occupancy ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      used   <= '0;
      dq_cnt <= '0;
      dq_wp  <= '0;
      dq_rp  <= '0;
    end else begin
      used   <= used + UW'(in_fire) - UW'(eg_take);
      dq_cnt <= dq_cnt + QW'(in_last) - QW'(eg_pop);
      if (in_last) dq_wp <= dq_wp + QAW'(1);
      if (eg_pop)  dq_rp <= dq_rp + QAW'(1);
    end
  end

endmodule

// File: rtl/adnode_chk.sv
module adnode_chk #(
  parameter int WORD_W = 16,
  parameter int TAG_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              cfg_valid,
  input logic [TAG_W-1:0]  func,
  input logic              proc,
  input logic              eg_idle
);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7
  cfg_keep_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> cfg_valid);

  // R8
  func_gap_chk: assert property (@(posedge clk) disable iff (rst)
    !eg_idle |=> $stable(func));

  // R2
  proc_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    proc && !eg_idle |-> cfg_valid);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !cfg_valid);

endmodule

bind adaptive_tag_node adnode_chk #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .cfg_valid(cfg_valid), .func(func), .proc(proc),
  .eg_idle(eg_idle)
);

// File: tb/sim_adaptive_tag_node.sv
`timescale 1ns/1ps
module sim_adaptive_tag_node;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;

  // current packet description
  int          ntag;
  int          tg [8];
  int          nd;
  logic [15:0] dt [16];

  always #4 clk = ~clk;

  adaptive_tag_node u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put_word(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send_pkt();
    put_word(16'(3 + ntag + nd));
    for (int i = 0; i < ntag; i++) put_word(16'(tg[i]));
    put_word(16'hFFFF);
    put_word(16'(nd));
    for (int i = 0; i < nd; i++) put_word(dt[i]);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic get_word(output logic [15:0] w);
    @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    w = out_data;
    @(posedge clk);
  endtask

  // expected packet built from R3/R4/R5 and the expected decision
  task automatic recv_check(input bit exp_proc, input string req);
    logic [15:0] ex [32];
    int          nx;
    logic [15:0] w;
    int          t;
    nx = 0;
    t  = (ntag > 0) ? tg[0] : 0;
    ex[nx++] = 16'(3 + ntag + nd - (exp_proc ? 1 : 0));
    for (int i = (exp_proc ? 1 : 0); i < ntag; i++) ex[nx++] = 16'(tg[i]);
    ex[nx++] = 16'hFFFF;
    ex[nx++] = 16'(nd);
    for (int n = 0; n < nd; n++) begin
      int acc;
      acc = 0;
      for (int k = 0; k < 4; k++) begin
        if (n - k >= 0) begin
          int c;
          c = (t + 1) * (k + 1);
          if (k % 2 == 1) c = -c;
          acc += c * int'($signed(dt[n-k]));
        end
      end
      ex[nx++] = exp_proc ? acc[15:0] : dt[n];
    end
    for (int i = 0; i < nx; i++) begin
      get_word(w);
      check(w == ex[i], req, int'(w), int'(ex[i]));
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pkt(input bit exp_proc, input string req);
    send_pkt();
    recv_check(exp_proc, req);
  endtask

  task automatic set_small(input int t0, input int t1, input int nt, input logic [15:0] d0);
    ntag = nt; tg[0] = t0; tg[1] = t1;
    nd = 1; dt[0] = d0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_first_config();
    // R2 R3: tagless packet passes unchanged and configures nothing
    ntag = 0; nd = 2; dt[0] = 16'd7; dt[1] = 16'd9;
    pkt(1'b0, "R2 tagless passthrough");
    // R7 R5: first tagged packet configures tag 3, impulse response 4,-8,12,-16,0
    ntag = 1; tg[0] = 3; nd = 5;
    dt[0] = 16'd1; dt[1] = 16'd0; dt[2] = 16'd0; dt[3] = 16'd0; dt[4] = 16'd0;
    pkt(1'b1, "R7 R5 first tag impulse");
  endtask

  task automatic t_leading_only();
    // R10: second tag matches, first does not; counts tie so function stays 3
    ntag = 2; tg[0] = 5; tg[1] = 3; nd = 2; dt[0] = 16'd100; dt[1] = 16'hFF00;
    pkt(1'b0, "R10 second tag ignored");
    // R4: processed, tag 5 remains
    ntag = 2; tg[0] = 3; tg[1] = 5; nd = 3; dt[0] = 16'd1; dt[1] = 16'd2; dt[2] = 16'd3;
    pkt(1'b1, "R4 consumed tag removed");
  endtask

  task automatic t_filter_mix();
    ntag = 1; tg[0] = 3; nd = 6;
    dt[0] = 16'd30000; dt[1] = 16'hFFFF; dt[2] = 16'h8000;
    dt[3] = 16'd12345; dt[4] = 16'h7FFF; dt[5] = 16'hF000;
    pkt(1'b1, "R5 signed wrap data");
  endtask

  task automatic t_switch();
    // counts: tag3 = 3; tag6 climbs 1,2,3 (tie keeps 3), then 4 switches
    for (int i = 1; i <= 3; i++) begin
      set_small(6, 0, 1, 16'd5);
      pkt(1'b0, "R6 R8 not yet majority");
    end
    set_small(6, 0, 1, 16'd5);
    pkt(1'b1, "R8 strict majority switches");
    set_small(3, 0, 1, 16'd5);
    pkt(1'b0, "R8 tie keeps function");
  endtask

  task automatic t_backpressure();
    logic [15:0] held;
    int          guard;
    ntag = 1; tg[0] = 6; nd = 3; dt[0] = 16'd2; dt[1] = 16'hFFFE; dt[2] = 16'd40;
    send_pkt();
    guard = 0;
    @(negedge clk);
    while (!out_valid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    held = out_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R11 valid held", int'(out_valid), 1);
      check(out_data == held, "R11 data held", int'(out_data), int'(held));
    end
    send_pkt();
    check(1'b1, "R12 second packet accepted", 1, 1);
    recv_check(1'b1, "R12 first packet");
    recv_check(1'b1, "R12 second packet");
  endtask

  task automatic t_decay();
    do_reset();
    for (int i = 0; i < 254; i++) begin
      set_small(0, 0, 1, 16'd1);
      pkt(1'b1, "R9 build tag0");
    end
    for (int i = 0; i < 100; i++) begin
      set_small(1, 0, 1, 16'd1);
      pkt(1'b0, "R9 tag1 minority");
    end
    set_small(0, 0, 1, 16'd1);
    pkt(1'b1, "R9 saturating hit");
    for (int i = 0; i < 77; i++) begin
      set_small(1, 0, 1, 16'd1);
      pkt(1'b0, "R9 tag1 below halved tag0");
    end
    set_small(1, 0, 1, 16'd1);
    pkt(1'b1, "R9 switch after halving");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_first_config();
    t_leading_only();
    t_filter_mix();
    t_switch();
    t_backpressure();
    t_decay();
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule